// File: doc/BRIEF.md
# Sector Signature Verification Controller

This controller sequences sector-by-sector checking of memory signatures for one channel. An external compressor folds data patterns into a running 64-bit signature. The controller counts the compressed patterns against a programmed sector length. At the end of every sector it tells the compressor to clear its running signature, and it captures the finished value into a held sector-signature register.

The channel works in one of three modes. In automatic mode a DMA engine supplies the expected signature for each sector. The controller compares every captured signature in full against that expected value, raises a sticky fail interrupt on a mismatch, and then raises a DMA request for the next expected value. In semi-CPU mode the controller raises a completion interrupt at each sector end and leaves the comparison to software. It watches whether software read the held signature before the next capture overwrote it, and reports an overrun when that interrupt is enabled. In full-CPU mode the controller stays passive: it does no counting, no capture, no interrupts and no DMA requests, and software drives the whole check.

Top module: `sig_verify_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all three interrupt flags, `dma_req_o` and `psa_clr_o` are 0 after that edge, and `sec_sig_o` is 0.
- R2: In the cycle after `mode_i` changes to automatic (2'b10) from any other mode, including the first edge after reset with `mode_i` already automatic, `dma_req_o` is 1.
- R3: In automatic or semi-CPU mode, the edge that accepts the pattern completing a sector (the `sector_len_i`-th pattern since the last sector end; a length of 0 counts as 1) makes `psa_clr_o` 1 for the following cycle. The next edge loads `sec_sig_o` with `psa_sig_i`. Fewer patterns give no `psa_clr_o`.
- R4: In automatic mode a capture whose `psa_sig_i` differs in any of the 64 bits from the expected value sets `fail_irq_o`. A capture that matches in all 64 bits does not set it.
- R5: In automatic mode every capture sets `dma_req_o`. A write on `exp_we_i` clears it unless a capture sets it on the same edge.
- R6: Outside automatic mode `dma_req_o` is 0 from the next edge on. `done_irq_o` is set by captures in semi-CPU mode (2'b01) only, and `fail_irq_o` by captures in automatic mode only.
- R7: In semi-CPU mode each capture marks the held signature unread, and a pulse on `sec_sig_rd_i` marks it read. A semi-CPU capture while it is still unread and no read occurs on that edge sets `ovr_irq_o` when `ovr_en_i` is 1.
- R8: With `ovr_en_i` at 0 an overrun condition leaves `ovr_irq_o` at 0.
- R9: In full-CPU mode (2'b00 or 2'b11) patterns cause no `psa_clr_o`, `sec_sig_o` keeps its value, and no flag or DMA request is set.
- R10: Writing 1 to `irq_clr_i` bit 0, 1 or 2 clears fail, done or overrun respectively. A set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 2'b10 automatic, 2'b01 semi-CPU, otherwise full-CPU |
| sector_len_i | input | CNT_W | Patterns per sector (0 treated as 1) |
| pat_valid_i | input | 1 | One pattern compressed this cycle |
| psa_sig_i | input | SIG_W | Running signature from the compressor |
| exp_we_i | input | 1 | Write strobe of the expected-value register |
| exp_data_i | input | SIG_W | Expected signature written by DMA |
| sec_sig_rd_i | input | 1 | Software read of the held sector signature |
| ovr_en_i | input | 1 | Overrun interrupt enable |
| irq_clr_i | input | 3 | Write-one-to-clear: bit0 fail, bit1 done, bit2 overrun |
| psa_clr_o | output | 1 | Clear pulse to the compressor at sector end |
| sec_sig_o | output | SIG_W | Held sector signature |
| fail_irq_o | output | 1 | Sticky signature-mismatch interrupt |
| done_irq_o | output | 1 | Sticky compression-complete interrupt |
| ovr_irq_o | output | 1 | Sticky overrun interrupt |
| dma_req_o | output | 1 | Level request for the next expected value |

## Verification
The bound assertions check, on every cycle, that the DMA request only exists in automatic mode, that fail and done flags only rise in their own modes, that the overrun flag never rises while disabled, that a compressor clear follows an accepted pattern and never occurs in full-CPU mode, and that flags only fall through write-one-to-clear. Only the bench scenarios can show the value-dependent behaviour: which 64-bit differences count as mismatches, the exact pattern count that ends a sector including a length of 0, the read-versus-overwrite ordering that decides overrun, and the same-edge priority of set over clear.

// File: rtl/sig_verify_pkg.sv
package sig_verify_pkg;
  localparam logic [1:0] MODE_FULL = 2'b00;
  localparam logic [1:0] MODE_SEMI = 2'b01;
  localparam logic [1:0] MODE_AUTO = 2'b10;

  localparam int FLAG_FAIL = 0;
  localparam int FLAG_DONE = 1;
  localparam int FLAG_OVR  = 2;
  localparam int NFLAG     = 3;

  function automatic logic is_counting(input logic [1:0] m);
    return (m == MODE_AUTO) || (m == MODE_SEMI);
  endfunction
endpackage

// File: rtl/svc_pat_counter.sv
module svc_pat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en_i,
  input  logic [CNT_W-1:0] sector_len_i,
  input  logic             pat_valid_i,
  output logic             sector_end_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] len_eff;
  logic [EXT_W-1:0] cnt_next;
  logic             last_pat;

  always_comb begin
    len_eff  = (sector_len_i == '0) ? EXT_W'(1) : {1'b0, sector_len_i};
    cnt_next = {1'b0, cnt_q} + EXT_W'(1);
    last_pat = cnt_next >= len_eff;
  end

  always_ff @(posedge clk) begin
    if (rst || !count_en_i) begin
      cnt_q        <= '0;
      sector_end_o <= 1'b0;
    end else if (pat_valid_i) begin
      if (last_pat) begin
        cnt_q        <= '0;
        sector_end_o <= 1'b1;
      end else begin
        cnt_q        <= cnt_next[CNT_W-1:0];
        sector_end_o <= 1'b0;
      end
    end else begin
      sector_end_o <= 1'b0;
    end
  end
endmodule

// File: rtl/svc_sig_capture.sv
module svc_sig_capture #(
  parameter int SIG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic             semi_i,
  input  logic [SIG_W-1:0] psa_sig_i,
  input  logic             rd_i,
  output logic [SIG_W-1:0] sec_sig_o,
  output logic             overrun_o
);
  logic unread_q;

  assign overrun_o = cap_i && semi_i && unread_q && !rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_sig_o <= '0;
    end else if (cap_i) begin
      sec_sig_o <= psa_sig_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !semi_i) begin
      unread_q <= 1'b0;
    end else if (cap_i) begin
      unread_q <= 1'b1;
    end else if (rd_i) begin
      unread_q <= 1'b0;
    end
  end
endmodule

// File: rtl/svc_expect_dma.sv
module svc_expect_dma #(
  parameter int SIG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_i,
  input  logic             cap_i,
  input  logic [SIG_W-1:0] psa_sig_i,
  input  logic             exp_we_i,
  input  logic [SIG_W-1:0] exp_data_i,
  output logic             mismatch_o,
  output logic             dma_req_o
);
  logic [SIG_W-1:0] exp_q;
  logic             auto_q;
  logic             enter_auto;

  assign enter_auto = auto_i && !auto_q;
  assign mismatch_o = cap_i && auto_i && (psa_sig_i != exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= '0;
    end else if (exp_we_i) begin
      exp_q <= exp_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q    <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      auto_q <= auto_i;
      if (!auto_i) begin
        dma_req_o <= 1'b0;
      end else if (enter_auto || cap_i) begin
        dma_req_o <= 1'b1;
      end else if (exp_we_i) begin
        dma_req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/svc_irq_flags.sv
module svc_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_o[g] <= 1'b0;
      end else if (set_i[g]) begin
        flag_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        flag_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sig_verify_ctrl.sv
module sig_verify_ctrl
  import sig_verify_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] sector_len_i,
  input  logic             pat_valid_i,
  input  logic [SIG_W-1:0] psa_sig_i,
  input  logic             exp_we_i,
  input  logic [SIG_W-1:0] exp_data_i,
  input  logic             sec_sig_rd_i,
  input  logic             ovr_en_i,
  input  logic [2:0]       irq_clr_i,
  output logic             psa_clr_o,
  output logic [SIG_W-1:0] sec_sig_o,
  output logic             fail_irq_o,
  output logic             done_irq_o,
  output logic             ovr_irq_o,
  output logic             dma_req_o
);
  logic             is_auto;
  logic             is_semi;
  logic             count_en;
  logic             sector_end;
  logic             mismatch;
  logic             overrun;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flags;

  assign is_auto  = (mode_i == MODE_AUTO);
  assign is_semi  = (mode_i == MODE_SEMI);
  assign count_en = is_counting(mode_i);

  svc_pat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .count_en_i   (count_en),
    .sector_len_i (sector_len_i),
    .pat_valid_i  (pat_valid_i),
    .sector_end_o (sector_end)
  );

  assign psa_clr_o = sector_end;

  svc_sig_capture #(.SIG_W(SIG_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_i     (sector_end),
    .semi_i    (is_semi),
    .psa_sig_i (psa_sig_i),
    .rd_i      (sec_sig_rd_i),
    .sec_sig_o (sec_sig_o),
    .overrun_o (overrun)
  );

  svc_expect_dma #(.SIG_W(SIG_W)) u_dma (
    .clk        (clk),
    .rst        (rst),
    .auto_i     (is_auto),
    .cap_i      (sector_end),
    .psa_sig_i  (psa_sig_i),
    .exp_we_i   (exp_we_i),
    .exp_data_i (exp_data_i),
    .mismatch_o (mismatch),
    .dma_req_o  (dma_req_o)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_FAIL] = mismatch;
    flag_set[FLAG_DONE] = sector_end && is_semi;
    flag_set[FLAG_OVR]  = overrun && ovr_en_i;
  end

  svc_irq_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (irq_clr_i),
    .flag_o (flags)
  );

  assign fail_irq_o = flags[FLAG_FAIL];
  assign done_irq_o = flags[FLAG_DONE];
  assign ovr_irq_o  = flags[FLAG_OVR];
endmodule

// File: rtl/svc_checker.sv
module svc_checker
  import sig_verify_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       pat_valid_i,
  input logic       ovr_en_i,
  input logic [2:0] irq_clr_i,
  input logic       psa_clr_o,
  input logic       fail_irq_o,
  input logic       done_irq_o,
  input logic       ovr_irq_o,
  input logic       dma_req_o
);
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!fail_irq_o && !done_irq_o && !ovr_irq_o && !dma_req_o && !psa_clr_o)); // R1

  AST_CLR_AFTER_PAT: assert property (@(posedge clk) disable iff (rst)
    psa_clr_o |-> $past(pat_valid_i)); // R3

  AST_FAIL_IN_AUTO: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_irq_o) |-> $past(mode_i) == MODE_AUTO); // R4

  AST_DMA_ONLY_AUTO: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |-> $past(mode_i) == MODE_AUTO); // R6

  AST_DONE_IN_SEMI: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq_o) |-> $past(mode_i) == MODE_SEMI); // R6

  AST_OVR_IN_SEMI: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_irq_o) |-> $past(mode_i) == MODE_SEMI); // R7

  AST_OVR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_irq_o) |-> $past(ovr_en_i)); // R8

  AST_FULL_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    psa_clr_o |-> is_counting($past(mode_i))); // R9

  AST_FAIL_FALL_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_irq_o) |-> $past(irq_clr_i[0])); // R10

  AST_DONE_FALL_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(done_irq_o) |-> $past(irq_clr_i[1])); // R10

  AST_OVR_FALL_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_irq_o) |-> $past(irq_clr_i[2])); // R10
endmodule

bind sig_verify_ctrl svc_checker u_svc_checker (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .pat_valid_i (pat_valid_i),
  .ovr_en_i    (ovr_en_i),
  .irq_clr_i   (irq_clr_i),
  .psa_clr_o   (psa_clr_o),
  .fail_irq_o  (fail_irq_o),
  .done_irq_o  (done_irq_o),
  .ovr_irq_o   (ovr_irq_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/test_sig_verify_ctrl.sv
module test_sig_verify_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_W = 64;
  localparam int CNT_W = 16;
  localparam logic [1:0] M_FULL = 2'b00;
  localparam logic [1:0] M_SEMI = 2'b01;
  localparam logic [1:0] M_AUTO = 2'b10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = M_AUTO;
  logic [CNT_W-1:0] sector_len_i = 16'd3;
  logic             pat_valid_i = 1'b0;
  logic [SIG_W-1:0] psa_sig_i = '0;
  logic             exp_we_i = 1'b0;
  logic [SIG_W-1:0] exp_data_i = '0;
  logic             sec_sig_rd_i = 1'b0;
  logic             ovr_en_i = 1'b1;
  logic [2:0]       irq_clr_i = 3'b000;
  logic             psa_clr_o;
  logic [SIG_W-1:0] sec_sig_o;
  logic             fail_irq_o, done_irq_o, ovr_irq_o, dma_req_o;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  bit  last_clr;
  logic [SIG_W-1:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_verify_ctrl #(.SIG_W(SIG_W), .CNT_W(CNT_W)) i_sig_verify_ctrl (.*);

  task automatic chk(input string req, input logic [SIG_W-1:0] act, input logic [SIG_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_fail(input logic [SIG_W-1:0] sig, input logic [SIG_W-1:0] ref_v);
    return sig != ref_v;
  endfunction

  // n patterns back to back; last_clr holds psa_clr_o in the cycle after the last one
  task automatic run_sector(input int n);
    last_clr = 0;
    pat_valid_i = 1'b1;
    repeat (n) @(negedge clk);
    pat_valid_i = 1'b0;
    last_clr = psa_clr_o;
    @(negedge clk);
  endtask

  task automatic write_exp(input logic [SIG_W-1:0] v);
    exp_we_i = 1'b1; exp_data_i = v;
    @(negedge clk);
    exp_we_i = 1'b0;
  endtask

  task automatic clear_irq(input logic [2:0] m);
    irq_clr_i = m;
    @(negedge clk);
    irq_clr_i = 3'b000;
  endtask

  task automatic read_sig();
    sec_sig_rd_i = 1'b1;
    @(negedge clk);
    sec_sig_rd_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fail", fail_irq_o, 0);
    chk("R1 done", done_irq_o, 0);
    chk("R1 ovr", ovr_irq_o, 0);
    chk("R1 dma", dma_req_o, 0);
    chk("R1 sig", sec_sig_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 dma after reset in auto", dma_req_o, 1);

    write_exp(64'h0123_4567_89ab_cdef);
    chk("R5 dma cleared by write", dma_req_o, 0);

    // matching sector
    psa_sig_i = 64'h0123_4567_89ab_cdef;
    run_sector(3);
    chk("R3 clr pulse", last_clr, 1);
    chk("R3 capture", sec_sig_o, 64'h0123_4567_89ab_cdef);
    chk("R4 match no fail", fail_irq_o, 0);
    chk("R5 dma after sector", dma_req_o, 1);

    // bit 0 difference
    write_exp(64'h0123_4567_89ab_cdef);
    psa_sig_i = 64'h0123_4567_89ab_cdee;
    run_sector(3);
    chk("R4 bit0 mismatch", fail_irq_o, 1);
    clear_irq(3'b001);
    chk("R10 fail cleared", fail_irq_o, 0);

    // bit 63 difference
    psa_sig_i = 64'h8123_4567_89ab_cdef;
    run_sector(3);
    chk("R4 bit63 mismatch", fail_irq_o, 1);
    clear_irq(3'b001);

    // random automatic sectors
    for (int i = 0; i < 16; i++) begin
      logic [SIG_W-1:0] ev;
      bit mis;
      int len;
      len = 1 + int'($urandom % 5);
      sector_len_i = CNT_W'(len);
      ev = {$urandom, $urandom};
      mis = $urandom % 2;
      write_exp(ev);
      psa_sig_i = mis ? (ev ^ (64'd1 << ($urandom % 64))) : ev;
      run_sector(len);
      chk("R3 random clr", last_clr, 1);
      chk("R4 random compare", fail_irq_o, exp_fail(psa_sig_i, ev));
      chk("R5 random dma", dma_req_o, 1);
      clear_irq(3'b001);
    end

    // semi-CPU mode
    mode_i = M_SEMI; sector_len_i = 16'd2; ovr_en_i = 1'b1;
    @(negedge clk);
    chk("R6 no dma in semi", dma_req_o, 0);
    psa_sig_i = 64'hdead_beef_0000_0001;
    run_sector(2);
    chk("R6 done set", done_irq_o, 1);
    chk("R6 no fail in semi", fail_irq_o, 0);
    chk("R3 semi capture", sec_sig_o, 64'hdead_beef_0000_0001);
    chk("R7 first capture no ovr", ovr_irq_o, 0);
    clear_irq(3'b010);
    chk("R10 done cleared", done_irq_o, 0);
    psa_sig_i = 64'hdead_beef_0000_0002;
    run_sector(2);
    chk("R7 unread overrun", ovr_irq_o, 1);
    chk("R6 dma stays low", dma_req_o, 0);
    clear_irq(3'b110);
    chk("R10 ovr cleared", ovr_irq_o, 0);
    read_sig();
    run_sector(2);
    chk("R7 read prevents ovr", ovr_irq_o, 0);
    ovr_en_i = 1'b0;
    run_sector(2);
    chk("R8 disabled ovr", ovr_irq_o, 0);
    ovr_en_i = 1'b1;
    read_sig();
    clear_irq(3'b010);

    // same-edge set beats clear
    sector_len_i = 16'd1;
    pat_valid_i = 1'b1;
    @(negedge clk);
    pat_valid_i = 1'b0;
    irq_clr_i = 3'b010;
    @(negedge clk);
    irq_clr_i = 3'b000;
    chk("R10 set wins over clear", done_irq_o, 1);
    read_sig();

    // length 0 acts as 1
    sector_len_i = 16'd0;
    run_sector(1);
    chk("R3 len0 ends sector", last_clr, 1);
    read_sig();

    // partial sector then completion
    sector_len_i = 16'd4;
    run_sector(3);
    chk("R3 short of length", last_clr, 0);
    run_sector(1);
    chk("R3 exact length", last_clr, 1);
    clear_irq(3'b111);

    // full-CPU mode
    mode_i = M_FULL;
    @(negedge clk);
    held = sec_sig_o;
    psa_sig_i = {$urandom, $urandom};
    run_sector(8);
    chk("R9 no clr", last_clr, 0);
    chk("R9 sig held", sec_sig_o, held);
    chk("R9 no done", done_irq_o, 0);
    chk("R9 no dma", dma_req_o, 0);
    chk("R9 no fail", fail_irq_o, 0);
    mode_i = M_AUTO;
    @(negedge clk);
    chk("R2 dma on entering auto", dma_req_o, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule